// File: doc/BRIEF.md
# Divide-by-Three Processor Clock Generator

This block turns a fast, free-running oscillator clock into a processor clock at one third of the oscillator frequency. The processor clock is high for one oscillator period and low for the next two, which gives a 33% duty cycle. The clock is taken straight from a bit of a three-state counter register, so the output cannot glitch. A second, slower clock for peripherals toggles on every rising edge of the processor clock. This gives half the processor frequency at a 50% duty cycle.

The block also conditions two asynchronous control inputs for logic that runs on the generated processor clock:

- **Reset.** The reset input is an active-low level, for example from an RC network. Its assertion takes effect at once. Its release passes through a chain of synchronizer flops clocked by the processor clock, so the reset seen downstream always drops exactly at a processor clock rising edge.
- **Ready.** The ready input passes through a two-flop synchronizer on the same processor clock edge. This synchronizer is cleared while the synchronized reset is active.

Both clocks keep running while reset is held, so downstream logic receives edges throughout reset.

Top module: `cpu_clkgen_top`

## Requirements
- R1: `cpu_clk` has a period of exactly three `osc_clk` periods. An internal 2-bit phase code steps 00, 01, 10 and back to 00. `cpu_clk` equals bit 1 of that code, and the code starts at 00 at power-up.
- R2: Every high phase of `cpu_clk` lasts exactly one `osc_clk` period.
- R3: Every low phase of `cpu_clk` lasts exactly two `osc_clk` periods.
- R4: `periph_clk` starts at 0 and inverts at every rising edge of `cpu_clk`. Its period is therefore six `osc_clk` periods, with a 50% duty cycle.
- R5: `sync_rst` is 1 at power-up. It becomes 1 as soon as `rst_in_n` is 0, without waiting for any clock edge.
- R6: After `rst_in_n` returns to 1, `sync_rst` falls at the second rising edge of `cpu_clk` and at no other time.
- R7: Once released, `sync_rst` stays at 0 for as long as `rst_in_n` stays at 1.
- R8: With `sync_rst` low, `sync_rdy` shows the value that `rdy_async` had at the rising edge of `cpu_clk` two edges earlier.
- R9: At every `cpu_clk` rising edge where `sync_rst` was 1, both ready stages are cleared, so `sync_rdy` reads 0. This holds whatever value `rdy_async` has.
- R10: `cpu_clk` and `periph_clk` keep their R1 to R4 waveforms while `rst_in_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Free-running oscillator clock |
| rst_in_n | input | 1 | Asynchronous reset request, active low |
| rdy_async | input | 1 | Asynchronous ready request, active high |
| cpu_clk | output | 1 | Processor clock, osc/3, 33% duty |
| periph_clk | output | 1 | Peripheral clock, cpu/2, 50% duty |
| sync_rst | output | 1 | Reset synchronized to `cpu_clk`, active high |
| sync_rdy | output | 1 | Ready synchronized to `cpu_clk` |

## Verification
The assertions check the following on every oscillator or processor edge:
- the phase-code order of the divider;
- the one-period high time and the two-period low time of the processor clock;
- that a released reset stays released;
- that the ready stages are cleared while the synchronized reset is active.

Only the bench scenarios can show the rest:
- that the reset is released exactly at the second processor edge, for releases at each of the three divider phases;
- the two-edge delay of ready pulses of different widths;
- the immediate effect of reset assertion in the middle of a cycle;
- the peripheral clock phase.

The bench shows these by comparing every output with a behavioural model at every oscillator cycle.

// File: rtl/cpu_clkgen_pkg.sv
package cpu_clkgen_pkg;

  // Phase code of the divide-by-three counter; bit 1 is the output clock.
  typedef enum logic [1:0] {
    PH_LOW_A = 2'b00,
    PH_LOW_B = 2'b01,
    PH_HIGH  = 2'b10,
    PH_BAD   = 2'b11
  } div_phase_e;

  localparam int MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/cg_div3.sv
module cg_div3
  import cpu_clkgen_pkg::*;
(
  input  logic osc_clk,
  input  logic arst_n,
  output logic clk_o
);

  div_phase_e phase_q = PH_LOW_A;

  // Unused code 11 falls back to 00 on the next edge.
  always_ff @(posedge osc_clk) begin
    case (phase_q)
      PH_LOW_A: phase_q <= PH_LOW_B;
      PH_LOW_B: phase_q <= PH_HIGH;
      default:  phase_q <= PH_LOW_A;
    endcase
  end

  // Output is a flop bit, never a decode.
  assign clk_o = phase_q[1];

  a_r1_low_a_to_low_b: assert property (@(posedge osc_clk) disable iff (!arst_n)
    phase_q == PH_LOW_A |=> phase_q == PH_LOW_B);
  a_r1_high_to_low_a: assert property (@(posedge osc_clk) disable iff (!arst_n)
    phase_q == PH_HIGH |=> phase_q == PH_LOW_A);
  a_r2_high_one_period: assert property (@(posedge osc_clk) disable iff (!arst_n)
    clk_o |=> !clk_o);
  a_r3_low_two_periods: assert property (@(posedge osc_clk) disable iff (!arst_n)
    $fell(clk_o) |=> !clk_o);

endmodule

// File: rtl/cg_half_div.sv
module cg_half_div (
  input  logic clk,
  output logic clk_o
);

  logic tgl_q = 1'b0;

  always_ff @(posedge clk) begin
    tgl_q <= ~tgl_q;
  end

  assign clk_o = tgl_q;

endmodule

// File: rtl/cg_rst_sync.sv
module cg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_o
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q = '1;

  // Assert at once, release through the flop chain.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '1;
    else         chain_q <= {chain_q[LAST-1:0], 1'b0};
  end

  assign rst_o = chain_q[LAST];

  a_r7_stays_released: assert property (@(posedge clk) disable iff (!arst_n)
    !rst_o |=> !rst_o);

endmodule

// File: rtl/cg_rdy_sync.sv
module cg_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_i,
  input  logic rdy_i,
  output logic rdy_o
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q = '0;

  always_ff @(posedge clk) begin
    if (rst_i) chain_q <= '0;
    else       chain_q <= {chain_q[LAST-1:0], rdy_i};
  end

  assign rdy_o = chain_q[LAST];

  a_r9_clear_in_reset: assert property (@(posedge clk)
    rst_i |=> !rdy_o);

endmodule

// File: rtl/cpu_clkgen_top.sv
module cpu_clkgen_top
  import cpu_clkgen_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic osc_clk,
  input  logic rst_in_n,
  input  logic rdy_async,
  output logic cpu_clk,
  output logic periph_clk,
  output logic sync_rst,
  output logic sync_rdy
);

  localparam int STAGES = (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  logic cpu_clk_w;

  cg_div3 u_div3 (
    .osc_clk (osc_clk),
    .arst_n  (rst_in_n),
    .clk_o   (cpu_clk_w)
  );

  cg_half_div u_half (
    .clk   (cpu_clk_w),
    .clk_o (periph_clk)
  );

  cg_rst_sync #(.STAGES(STAGES)) u_rst_sync (
    .clk    (cpu_clk_w),
    .arst_n (rst_in_n),
    .rst_o  (sync_rst)
  );

  cg_rdy_sync #(.STAGES(STAGES)) u_rdy_sync (
    .clk   (cpu_clk_w),
    .rst_i (sync_rst),
    .rdy_i (rdy_async),
    .rdy_o (sync_rdy)
  );

  assign cpu_clk = cpu_clk_w;

endmodule

// File: tb/cpu_clkgen_top_tb_top.sv
`timescale 1ns/1ps
module cpu_clkgen_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic osc_clk = 1'b0;
  logic rst_in_n = 1'b0;
  logic rdy_async = 1'b0;
  logic cpu_clk, periph_clk, sync_rst, sync_rdy;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  // Behavioural reference state.
  int ref_phase = 0;
  int ref_pclk = 0;
  int rel_edges = 0;
  int rdy_hist[$] = '{0, 0};

  cpu_clkgen_top #(.SYNC_STAGES(2)) dut_i (
    .osc_clk    (osc_clk),
    .rst_in_n   (rst_in_n),
    .rdy_async  (rdy_async),
    .cpu_clk    (cpu_clk),
    .periph_clk (periph_clk),
    .sync_rst   (sync_rst),
    .sync_rdy   (sync_rdy)
  );

  always #(CLK_PERIOD/2) osc_clk = ~osc_clk;

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  // Reference update at each oscillator rising edge.
  always @(posedge osc_clk) begin
    bit rst_before;
    rst_before = (rel_edges < 2);
    ref_phase = (ref_phase == 2) ? 0 : ref_phase + 1;
    if (ref_phase == 2) begin
      ref_pclk = 1 - ref_pclk;
      if (rst_before) rdy_hist = '{0, 0};
      else begin
        rdy_hist.push_back(int'(rdy_async));
        void'(rdy_hist.pop_front());
      end
      if (rst_in_n && rel_edges < 2) rel_edges++;
    end
    if (!rst_in_n) rel_edges = 0;
  end

  // Compare away from the active edge.
  always @(negedge osc_clk) begin
    if (!rst_in_n) rel_edges = 0;
    if (!rst_in_n) begin
      check("R1 R2 R3 R10 cpu_clk", cpu_clk, ref_phase == 2);
      check("R4 R10 periph_clk", periph_clk, ref_pclk[0]);
      check("R5 sync_rst", sync_rst, 1'b1);
    end else begin
      check("R1 R2 R3 cpu_clk", cpu_clk, ref_phase == 2);
      check("R4 periph_clk", periph_clk, ref_pclk[0]);
      check("R6 R7 sync_rst", sync_rst, rel_edges < 2);
    end
    check("R8 R9 sync_rdy", sync_rdy, rdy_hist[0][0]);
  end

  task automatic drive(input logic rn, input logic rdy, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge osc_clk);
      #2;
      rst_in_n = rn;
      rdy_async = rdy;
    end
  endtask

  always @(posedge osc_clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    // R5: power-up state.
    check("R5 power-up sync_rst", sync_rst, 1'b1);
    check("R9 power-up sync_rdy", sync_rdy, 1'b0);
    // R9, R10: ready high during reset is blocked, clocks run.
    drive(1'b0, 1'b1, 12);
    // R6: releases at each of the three divider phases.
    for (int ph = 0; ph < 3; ph++) begin
      drive(1'b1, 1'b0, 14 + ph);
      drive(1'b0, 1'b0, 7);
    end
    drive(1'b1, 1'b0, 10);
    // R8: ready pulses of several widths.
    for (int w = 1; w < 10; w++) begin
      drive(1'b1, 1'b1, w);
      drive(1'b1, 1'b0, w + 2);
    end
    drive(1'b1, 1'b1, 20);
    // R5, R9: reassert mid-cycle with ready high.
    drive(1'b0, 1'b1, 1);
    drive(1'b0, 1'b1, 9);
    drive(1'b1, 1'b1, 15);
    // R7: long quiet stretch released.
    drive(1'b1, 1'b0, 40);
    done = 1;
    @(negedge osc_clk);
    #1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule